// File: doc/BRIEF.md
# Next Program Counter Unit

This block decides, within one cycle of combinational logic, which address a fixed-width 32-bit-instruction core fetches next. It takes the address of the current instruction, a 16-bit branch offset counted in instructions, a 26-bit jump field, a register value for indirect jumps, a one-bit result saying whether two register operands were equal, and a code giving the kind of control transfer. From these it drives the next fetch address and a flag that marks a redirect. For subroutine calls it also drives a return address and a write enable aimed at register 31.

The block sits between decode and the fetch register. There is no state and no handshake. Every output is a pure function of the present inputs. Other conditions, such as less-than, are expected to be reduced to an equality test on a set-less-than result before they reach this block. Delay slots and prediction are not handled here.

Transfer codes on `xfer_i`: 0 sequential, 1 branch when equal, 2 branch when not equal, 3 jump, 4 jump and link, 5 jump through register. Codes 6 and 7 are reserved.

Top module: `npc_unit`

## Requirements
- R1: With code 0, `next_pc_o` equals `pc_i + 4` (modulo 2^32), and both `taken_o` and `link_we_o` are 0.
- R2: With code 1 and `eq_i` = 1, `next_pc_o` equals `pc_i + 4 + (sign-extended disp_i shifted left by 2)`, and `taken_o` is 1.
- R3: A branch whose condition fails gives `next_pc_o = pc_i + 4` and `taken_o = 0`. This covers code 1 with `eq_i` = 0 and code 2 with `eq_i` = 1.
- R4: With code 2 and `eq_i` = 0, the branch is taken and goes to the same target as in R2.
- R5: A displacement with bit 15 set moves the target backwards. The sum wraps modulo 2^32.
- R6: With code 3, `next_pc_o` is formed from three fields, from high to low: bits 31..28 of `pc_i + 4`, then `jtgt_i`, then two zero bits. `taken_o` is 1. The upper four bits come from `pc_i + 4` even when that sum crosses a 256 MiB boundary.
- R7: With code 4, the target and `taken_o` are the same as in R6. In addition, `link_we_o` is 1 and `link_val_o` equals `pc_i + 4`.
- R8: With code 5, `next_pc_o` equals `rs_val_i` unchanged, including its low two bits, and `taken_o` is 1.
- R9: `link_we_o` is 1 only for code 4. `link_idx_o` is always 31, and `link_val_o` is always `pc_i + 4`.
- R10: Reserved codes 6 and 7 behave as code 0.
- R11: `eq_i` has no effect on any output for codes other than 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Address of the current instruction |
| disp_i | input | 16 | Signed branch offset, counted in instructions |
| jtgt_i | input | 26 | Word index field of a pseudo-direct jump |
| rs_val_i | input | 32 | Register value used by indirect jumps |
| eq_i | input | 1 | 1 when the two compared register operands are equal |
| xfer_i | input | 3 | Control-transfer code |
| next_pc_o | output | 32 | Address to fetch next |
| taken_o | output | 1 | 1 when the flow leaves sequential order |
| link_val_o | output | 32 | Return address, equal to the current address plus 4 |
| link_we_o | output | 1 | Write enable for the return address |
| link_idx_o | output | 5 | Destination register index for the link, always 31 |

## Verification
The bench aims at the places where the arithmetic is easy to get wrong.

- **Displacement handling.**
  - Offsets of 0x7FFF and 0x8000 expose a design that zero-extends, because it would jump far forward instead of backward.
  - A design that forgets the shift by two would land a quarter of the way to the target.
- **Jump base.** A current address of 0x0FFFFFFC makes `pc_i + 4` cross into the next region. A design that takes the upper bits from `pc_i` instead of from the incremented address would jump into the wrong 256 MiB segment.
- **Branch polarity.** Both branch codes are driven with both equality values. An inverted polarity shows up as a swapped `taken_o`.
- **Link and reserved codes.** A stray link enable on a plain jump or on an indirect jump is caught. So is a reserved code that redirects the flow.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    XF_SEQ = 3'd0,
    XF_BEQ = 3'd1,
    XF_BNE = 3'd2,
    XF_JMP = 3'd3,
    XF_JAL = 3'd4,
    XF_JR  = 3'd5
  } xfer_e;

  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_BR  = 2'd1,
    SRC_ABS = 2'd2,
    SRC_REG = 2'd3
  } pc_src_e;
endpackage

// File: rtl/npc_targets.sv
module npc_targets #(
  parameter int ADDR_W   = 32,
  parameter int DISP_W   = 16,
  parameter int TGT_W    = 26,
  parameter int ALIGN_SH = 2
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] disp,
  input  logic [TGT_W-1:0]  jtgt,
  output logic [ADDR_W-1:0] seq_pc,
  output logic [ADDR_W-1:0] br_pc,
  output logic [ADDR_W-1:0] abs_pc
);
  localparam int STEP   = 1 << ALIGN_SH;
  localparam int EXT_W  = ADDR_W - DISP_W - ALIGN_SH;
  localparam int HIGH_W = ADDR_W - TGT_W - ALIGN_SH;

  logic [ADDR_W-1:0] disp_ext;

  always_comb begin
    seq_pc   = pc + ADDR_W'(STEP);
    disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp, {ALIGN_SH{1'b0}}};
    br_pc    = seq_pc + disp_ext;
    abs_pc   = {seq_pc[ADDR_W-1 -: HIGH_W], jtgt, {ALIGN_SH{1'b0}}};
  end

  // Pseudo-direct target keeps the region of the incremented address (R6)
  always_comb begin
    assert_abs_region_R6: assert (abs_pc[ADDR_W-1 -: HIGH_W] == seq_pc[ADDR_W-1 -: HIGH_W]
                                  && abs_pc[ALIGN_SH-1:0] == '0)
      else $error("absolute target left its region");
  end
endmodule

// File: rtl/npc_decide.sv
module npc_decide
  import npc_pkg::*;
(
  input  logic [2:0] xfer,
  input  logic       eq,
  output pc_src_e    src,
  output logic       taken,
  output logic       link_we
);
  always_comb begin
    src     = SRC_SEQ;
    link_we = 1'b0;
    case (xfer_e'(xfer))
      XF_BEQ: src = eq  ? SRC_BR : SRC_SEQ;
      XF_BNE: src = !eq ? SRC_BR : SRC_SEQ;
      XF_JMP: src = SRC_ABS;
      XF_JAL: begin
        src     = SRC_ABS;
        link_we = 1'b1;
      end
      XF_JR:  src = SRC_REG;
      default: src = SRC_SEQ;
    endcase
    taken = (src != SRC_SEQ);
  end

  // A link write always accompanies a redirect (R7)
  always_comb begin
    assert_link_implies_taken_R7: assert (!link_we || taken)
      else $error("link write without redirect");
  end
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  pc_src_e           src,
  input  logic [ADDR_W-1:0] seq_pc,
  input  logic [ADDR_W-1:0] br_pc,
  input  logic [ADDR_W-1:0] abs_pc,
  input  logic [ADDR_W-1:0] reg_pc,
  output logic [ADDR_W-1:0] next_pc
);
  always_comb begin
    case (src)
      SRC_BR:  next_pc = br_pc;
      SRC_ABS: next_pc = abs_pc;
      SRC_REG: next_pc = reg_pc;
      default: next_pc = seq_pc;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DISP_W   = 16,
  parameter int TGT_W    = 26,
  parameter int IDX_W    = 5,
  parameter int LINK_REG = 31
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [TGT_W-1:0]  jtgt_i,
  input  logic [ADDR_W-1:0] rs_val_i,
  input  logic              eq_i,
  input  logic [2:0]        xfer_i,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] link_val_o,
  output logic              link_we_o,
  output logic [IDX_W-1:0]  link_idx_o
);
  localparam int ALIGN_SH = 2;

  logic [ADDR_W-1:0] seq_pc, br_pc, abs_pc;
  pc_src_e           src;

  npc_targets #(
    .ADDR_W(ADDR_W), .DISP_W(DISP_W), .TGT_W(TGT_W), .ALIGN_SH(ALIGN_SH)
  ) u_targets (
    .pc(pc_i), .disp(disp_i), .jtgt(jtgt_i),
    .seq_pc(seq_pc), .br_pc(br_pc), .abs_pc(abs_pc)
  );

  npc_decide u_decide (
    .xfer(xfer_i), .eq(eq_i), .src(src), .taken(taken_o), .link_we(link_we_o)
  );

  npc_select #(.ADDR_W(ADDR_W)) u_select (
    .src(src), .seq_pc(seq_pc), .br_pc(br_pc), .abs_pc(abs_pc),
    .reg_pc(rs_val_i), .next_pc(next_pc_o)
  );

  assign link_val_o = seq_pc;
  assign link_idx_o = IDX_W'(LINK_REG);

  always_comb begin
    // Not taken means fall-through to the next instruction (R3)
    assert_fallthrough_R3: assert (taken_o || next_pc_o == link_val_o)
      else $error("untaken flow not sequential");
    // Link enable is reserved for jump-and-link (R9)
    assert_link_only_jal_R9: assert (!link_we_o || xfer_i == 3'd4)
      else $error("link enable on wrong code");
    // Indirect jumps pass the register through (R8)
    assert_reg_jump_R8: assert (xfer_i != 3'd5 || (next_pc_o == rs_val_i && taken_o))
      else $error("register jump wrong");
  end
endmodule

// File: tb/npc_unit_tb.sv
module npc_unit_tb;
  logic        clk = 1'b0;
  logic [31:0] pc_i, rs_val_i;
  logic [15:0] disp_i;
  logic [25:0] jtgt_i;
  logic        eq_i;
  logic [2:0]  xfer_i;
  logic [31:0] next_pc_o, link_val_o;
  logic        taken_o, link_we_o;
  logic [4:0]  link_idx_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  npc_unit u_dut (
    .pc_i(pc_i), .disp_i(disp_i), .jtgt_i(jtgt_i), .rs_val_i(rs_val_i),
    .eq_i(eq_i), .xfer_i(xfer_i), .next_pc_o(next_pc_o), .taken_o(taken_o),
    .link_val_o(link_val_o), .link_we_o(link_we_o), .link_idx_o(link_idx_o)
  );

  function automatic logic [31:0] exp_next(logic [31:0] pc, logic [15:0] d,
      logic [25:0] t, logic [31:0] r, logic e, logic [2:0] x);
    logic [31:0] inc;
    logic [31:0] off;
    inc = pc + 32'd4;
    off = {{16{d[15]}}, d} << 2;
    case (x)
      3'd1: return e ? inc + off : inc;
      3'd2: return !e ? inc + off : inc;
      3'd3, 3'd4: return {inc[31:28], t, 2'b00};
      3'd5: return r;
      default: return inc;
    endcase
  endfunction

  function automatic logic exp_taken(logic e, logic [2:0] x);
    case (x)
      3'd1: return e;
      3'd2: return !e;
      3'd3, 3'd4, 3'd5: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(string req, logic [31:0] pc, logic [15:0] d, logic [25:0] t,
      logic [31:0] r, logic e, logic [2:0] x);
    @(negedge clk);
    pc_i = pc; disp_i = d; jtgt_i = t; rs_val_i = r; eq_i = e; xfer_i = x;
    #1;
    check(req, "next_pc", next_pc_o, exp_next(pc, d, t, r, e, x));
    check(req, "taken", 32'(taken_o), 32'(exp_taken(e, x)));
    check("R9", "link_we", 32'(link_we_o), 32'(x == 3'd4));
    check("R9", "link_val", link_val_o, pc + 32'd4);
    check("R9", "link_idx", 32'(link_idx_o), 32'd31);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    pc_i = '0; disp_i = '0; jtgt_i = '0; rs_val_i = '0; eq_i = 1'b0; xfer_i = 3'd0;
    #1;
    check("R1", "idle next_pc", next_pc_o, 32'h4);
    check("R1", "idle taken", 32'(taken_o), 32'h0);

    // Directed corners
    apply("R1", 32'h0000_1000, 16'h0010, 26'h0, 32'h0, 1'b1, 3'd0);
    apply("R1", 32'hFFFF_FFFC, 16'h0, 26'h0, 32'h0, 1'b0, 3'd0);
    apply("R2", 32'h0000_1000, 16'h7FFF, 26'h0, 32'h0, 1'b1, 3'd1);
    apply("R3", 32'h0000_1000, 16'h0040, 26'h0, 32'h0, 1'b0, 3'd1);
    apply("R3", 32'h0000_1000, 16'h0040, 26'h0, 32'h0, 1'b1, 3'd2);
    apply("R4", 32'h0040_0020, 16'h0003, 26'h0, 32'h0, 1'b0, 3'd2);
    apply("R5", 32'h0000_1000, 16'h8000, 26'h0, 32'h0, 1'b1, 3'd1);
    apply("R5", 32'h0000_1000, 16'hFFFF, 26'h0, 32'h0, 1'b0, 3'd2);
    apply("R5", 32'h0000_0000, 16'hFFF0, 26'h0, 32'h0, 1'b1, 3'd1);
    apply("R6", 32'h0FFF_FFFC, 16'h0, 26'h3FF_FFFF, 32'h0, 1'b0, 3'd3);
    apply("R6", 32'hA000_0000, 16'h0, 26'h000_0001, 32'h0, 1'b1, 3'd3);
    apply("R7", 32'h1234_5678, 16'h0, 26'h2AA_AAAA, 32'h0, 1'b0, 3'd4);
    apply("R8", 32'h0000_1000, 16'h0, 26'h0, 32'hDEAD_BEEF, 1'b0, 3'd5);
    apply("R10", 32'h0000_2000, 16'h0100, 26'h155_5555, 32'h5555_0000, 1'b1, 3'd6);
    apply("R10", 32'h0000_2000, 16'h0100, 26'h155_5555, 32'h5555_0000, 1'b0, 3'd7);
    // R11: flip eq_i on non-branch codes; outputs must match the expectation either way
    for (int c = 0; c < 8; c++) begin
      if (c == 1 || c == 2) continue;
      apply("R11", 32'h8000_0100, 16'h1234, 26'h0ABCDEF, 32'h0000_0042, 1'b0, 3'(c));
      apply("R11", 32'h8000_0100, 16'h1234, 26'h0ABCDEF, 32'h0000_0042, 1'b1, 3'(c));
    end

    // Random stimulus with a fixed seed
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] x;
      string req;
      x = 3'($urandom_range(0, 7));
      case (x)
        3'd1: req = "R2";
        3'd2: req = "R4";
        3'd3: req = "R6";
        3'd4: req = "R7";
        3'd5: req = "R8";
        3'd6, 3'd7: req = "R10";
        default: req = "R1";
      endcase
      apply(req, $urandom, 16'($urandom), 26'($urandom), $urandom, 1'($urandom), x);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule